// File: doc/BRIEF.md
# Supply Power-Fail Access Controller

This block holds the decision logic that sits between a set of analog supply comparators and a battery-backed timekeeping core. It takes digital flags that say whether the main supply is above the power-fail threshold and whether it is above the battery voltage. A third flag says which of the two reference levels is the lower one. From these it chooses the supply that powers the core and decides whether the host may touch the clock registers.

Access is never allowed while the main supply is under the fail threshold. When the supply comes back, a recovery timer driven by a 1 kHz tick keeps access closed for a short time, but only while the oscillator is running. With the oscillator halted, access opens as soon as the supply is good again. Every flag passes through a two-flop synchronizer before any decision uses it. The tick is a synchronous single-cycle pulse and is used as it arrives.

Top module: `pwr_access_ctrl`

## Requirements
- R1: While reset is asserted, and until the first decision after reset release, the outputs show the battery selected (`sel_battery_o`=1), access disabled (`access_en_o`=0) and `access_blocked_o`=1.
- R2: `access_en_o` is 1 only while the synchronized main-above-threshold flag is 1. One cycle after that flag reads 0, `access_en_o` is 0.
- R3: With `pf_below_bat_i`=1, `sel_battery_o` is 1 exactly when the main supply is below the fail threshold (`vcc_ok_i`=0).
- R4: With `pf_below_bat_i`=0, `sel_battery_o` is 1 exactly when the main supply is below the battery (`vcc_gt_bat_i`=0).
- R5: With `pf_below_bat_i`=0, `vcc_ok_i`=0 and `vcc_gt_bat_i`=1, the main supply stays selected (`sel_battery_o`=0) and access stays blocked.
- R6: With the oscillator running, once the supply is good again access opens on the clock edge that samples the REC_TICKS-th `ms_tick_i` pulse (default 2) seen while the supply is good. It does not open earlier.
- R7: With the oscillator halted (`osc_run_i`=0), access opens one clock after the synchronized supply-good flag reads 1, and no tick is needed.
- R8: If the supply drops below the threshold during the recovery count, the count starts again from zero. A full REC_TICKS ticks are needed after the supply returns.
- R9: A change on any flag input affects the outputs on the third rising clock edge after it is driven. Outputs after the first and second edges still show the old decision.
- R10: `access_blocked_o` is always the inverse of `access_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| vcc_ok_i | input | 1 | Main supply above the power-fail threshold (asynchronous) |
| vcc_gt_bat_i | input | 1 | Main supply above the battery voltage (asynchronous) |
| pf_below_bat_i | input | 1 | Fail threshold lies below the battery voltage (asynchronous) |
| osc_run_i | input | 1 | Timekeeping oscillator is running (asynchronous) |
| ms_tick_i | input | 1 | Single-cycle 1 kHz tick, synchronous to clk |
| sel_battery_o | output | 1 | 1 selects the battery as the core supply, 0 the main supply |
| access_en_o | output | 1 | Host register access allowed |
| access_blocked_o | output | 1 | Host register access refused |

## Verification
The assertions take the millisecond tick to be a one-cycle pulse synchronous to `clk`. They also take the flags they see to be the synchronized copies, so any flag pattern at the pins is legal, including ones that cannot occur physically. The bench changes every input half a clock away from the active edge. It generates the tick on a fixed cycle grid, so a tick never spans two edges. It also sweeps flag combinations with no regard to analog plausibility, which keeps every case inside what the assertions accept.

// File: rtl/pwr_access_pkg.sv
package pwr_access_pkg;

  typedef enum logic [1:0] {
    ACC_BLOCKED = 2'd0,
    ACC_RECOVER = 2'd1,
    ACC_OPEN    = 2'd2
  } acc_state_e;

  // positions inside the synchronized flag vector
  localparam int unsigned FLG_VCC_OK  = 0;
  localparam int unsigned FLG_GT_BAT  = 1;
  localparam int unsigned FLG_PF_LOW  = 2;
  localparam int unsigned FLG_OSC_RUN = 3;
  localparam int unsigned FLG_COUNT   = 4;

endpackage

// File: rtl/pac_rst_sync.sv
module pac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pac_flag_sync.sv
module pac_flag_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pac_supply_sel.sv
module pac_supply_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  input  logic vcc_gt_bat,
  input  logic pf_below_bat,
  output logic sel_battery
);

  logic sel_d;
  logic sel_q;

  // Switchover point depends on which reference is lower.
  always_comb begin
    if (pf_below_bat) begin
      sel_d = ~vcc_ok;
    end else begin
      sel_d = ~vcc_gt_bat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel_battery = sel_q;

endmodule

// File: rtl/pac_recovery_fsm.sv
module pac_recovery_fsm
  import pwr_access_pkg::*;
#(
  parameter int unsigned REC_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  input  logic osc_run,
  input  logic tick,
  output logic access_en
);

  localparam int unsigned CNT_W = (REC_TICKS > 1) ? $clog2(REC_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_TICKS - 1);

  acc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!vcc_ok) begin
      state_d = ACC_BLOCKED;
      cnt_d   = '0;
    end else if (state_q != ACC_OPEN) begin
      if (!osc_run) begin
        state_d = ACC_OPEN;
        cnt_d   = '0;
      end else begin
        state_d = ACC_RECOVER;
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            state_d = ACC_OPEN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACC_BLOCKED;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign access_en = (state_q == ACC_OPEN);

  // R2
  no_access_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> state_q != ACC_OPEN);

  // R7
  halted_osc_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_ok && !osc_run) |=> state_q == ACC_OPEN);

  // R6
  no_early_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ACC_OPEN && osc_run && !tick) |=> state_q != ACC_OPEN);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  // R8
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> cnt_q == '0);

endmodule

// File: rtl/pwr_access_ctrl.sv
module pwr_access_ctrl
  import pwr_access_pkg::*;
#(
  parameter int unsigned REC_TICKS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok_i,
  input  logic vcc_gt_bat_i,
  input  logic pf_below_bat_i,
  input  logic osc_run_i,
  input  logic ms_tick_i,
  output logic sel_battery_o,
  output logic access_en_o,
  output logic access_blocked_o
);

  logic                 rst_core_n;
  logic [FLG_COUNT-1:0] flags_raw;
  logic [FLG_COUNT-1:0] flags_s;
  logic                 acc_en;

  pac_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  always_comb begin
    flags_raw              = '0;
    flags_raw[FLG_VCC_OK]  = vcc_ok_i;
    flags_raw[FLG_GT_BAT]  = vcc_gt_bat_i;
    flags_raw[FLG_PF_LOW]  = pf_below_bat_i;
    flags_raw[FLG_OSC_RUN] = osc_run_i;
  end

  pac_flag_sync #(
    .WIDTH (FLG_COUNT),
    .STAGES(SYNC_STAGES)
  ) u_flag_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .async_i(flags_raw),
    .sync_o (flags_s)
  );

  pac_supply_sel u_supply_sel (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .vcc_ok      (flags_s[FLG_VCC_OK]),
    .vcc_gt_bat  (flags_s[FLG_GT_BAT]),
    .pf_below_bat(flags_s[FLG_PF_LOW]),
    .sel_battery (sel_battery_o)
  );

  pac_recovery_fsm #(
    .REC_TICKS(REC_TICKS)
  ) u_recovery (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .vcc_ok   (flags_s[FLG_VCC_OK]),
    .osc_run  (flags_s[FLG_OSC_RUN]),
    .tick     (ms_tick_i),
    .access_en(acc_en)
  );

  assign access_en_o      = acc_en;
  assign access_blocked_o = ~acc_en;

endmodule

// File: tb/pwr_access_ctrl_tb.sv
module pwr_access_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int REC        = 2;
  localparam int TICK_DIV   = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b0, gt_bat = 1'b0, pf_low = 1'b0, osc = 1'b0;
  logic ms_tick = 1'b0;
  logic tick_on = 1'b0;
  logic sel_bat, acc_en, acc_blk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  pwr_access_ctrl #(.REC_TICKS(REC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .vcc_ok_i(vcc_ok), .vcc_gt_bat_i(gt_bat), .pf_below_bat_i(pf_low),
    .osc_run_i(osc), .ms_tick_i(ms_tick),
    .sel_battery_o(sel_bat), .access_en_o(acc_en), .access_blocked_o(acc_blk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int rst_wait;
  logic [3:0] hist [$];
  logic m_sel, m_open;
  int   m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_wait = 0;
      hist = {};
      hist.push_back(4'b0); hist.push_back(4'b0);
      m_sel = 1'b1; m_open = 1'b0; m_cnt = 0;
    end else if (rst_wait < 2) begin
      rst_wait++;
    end else begin
      logic [3:0] f;
      f = hist.pop_front();               // {osc, pf_low, gt_bat, vcc_ok}, two edges old
      m_sel = f[2] ? !f[0] : !f[1];
      if (!f[0]) begin
        m_open = 1'b0; m_cnt = 0;
      end else if (!m_open) begin
        if (!f[3]) begin
          m_open = 1'b1; m_cnt = 0;
        end else if (ms_tick) begin
          m_cnt++;
          if (m_cnt >= REC) begin m_open = 1'b1; m_cnt = 0; end
        end
      end
      hist.push_back({osc, pf_low, gt_bat, vcc_ok});
    end
  end

  task automatic check(string t, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {sel,en,blk} actual=%b expected=%b at t=%0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(tag, {sel_bat, acc_en, acc_blk}, {m_sel, m_open, !m_open});
      // R10
      check("R10", {2'b0, acc_blk}, {2'b0, !acc_en});
    end
  end

  // tick generator on a fixed grid
  int tdiv = 0;
  always @(negedge clk) begin
    if (tick_on) begin
      tdiv = (tdiv + 1) % TICK_DIV;
      ms_tick <= (tdiv == 0);
    end else begin
      ms_tick <= 1'b0;
    end
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    wait_neg(3);
    check("R1", {sel_bat, acc_en, acc_blk}, 3'b101);
    vcc_ok = 1'b1; gt_bat = 1'b1; pf_low = 1'b1; osc = 1'b0;
    #2 rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_neg(3);
    check("R1", {sel_bat, acc_en, acc_blk}, 3'b101);
    wait_neg(10);
    // R7 halted oscillator: open already
    tag = "R7";
    check("R7", {sel_bat, acc_en, acc_blk}, 3'b010);

    // R9 latency: pf drops
    tag = "R9";
    vcc_ok = 1'b0;
    wait_neg(1); check("R9", {sel_bat, acc_en, acc_blk}, 3'b010);
    wait_neg(1); check("R9", {sel_bat, acc_en, acc_blk}, 3'b010);
    wait_neg(1); check("R9", {sel_bat, acc_en, acc_blk}, 3'b101);

    // R3 threshold below battery
    tag = "R3";
    vcc_ok = 1'b0; gt_bat = 1'b1; wait_neg(6);
    check("R3", {2'b0, sel_bat}, 3'b001);
    vcc_ok = 1'b1; wait_neg(6);
    check("R3", {2'b0, sel_bat}, 3'b000);

    // R5 / R4 threshold above battery
    tag = "R5";
    pf_low = 1'b0; vcc_ok = 1'b0; gt_bat = 1'b1; wait_neg(6);
    check("R5", {sel_bat, acc_en, acc_blk}, 3'b001);
    tag = "R4";
    gt_bat = 1'b0; wait_neg(6);
    check("R4", {sel_bat, acc_en, acc_blk}, 3'b101);
    gt_bat = 1'b1; wait_neg(4);

    // R6 recovery with oscillator running
    tag = "R6";
    osc = 1'b1; tick_on = 1'b1; wait_neg(6);
    vcc_ok = 1'b1;
    begin
      int seen = 0;
      int waited = 0;
      while (!acc_en && waited < 200) begin
        @(posedge clk);
        if (ms_tick && u_dut_flags_ready()) seen++;
        @(negedge clk);
        waited++;
      end
      check("R6", {1'b0, acc_en, 1'b0}, 3'b010);
      check("R6", 3'(seen), 3'(REC));
    end

    // R8 drop during count restarts it
    tag = "R8";
    vcc_ok = 1'b0; wait_neg(8);
    vcc_ok = 1'b1;
    @(posedge ms_tick); wait_neg(4);
    vcc_ok = 1'b0; wait_neg(5);
    vcc_ok = 1'b1; wait_neg(4);
    @(posedge ms_tick); wait_neg(2);
    check("R8", {1'b0, acc_en, 1'b0}, 3'b000);
    @(posedge ms_tick); wait_neg(2);
    check("R8", {1'b0, acc_en, 1'b0}, 3'b010);

    // R1 mid-run reset
    tag = "R1";
    #2 rst_n = 1'b0;
    wait_neg(2);
    check("R1", {sel_bat, acc_en, acc_blk}, 3'b101);
    #2 rst_n = 1'b1;
    wait_neg(4);

    // R2 sweep of flag combinations
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom());
      vcc_ok = r[0] | r[3]; gt_bat = r[1]; pf_low = r[2]; osc = $urandom_range(0, 3) != 0;
      wait_neg($urandom_range(1, 25));
    end
    wait_neg(5);
    summary();
  end

  // flag good at the fsm once the supply has been high for three edges
  int good_run = 0;
  always @(posedge clk) good_run = vcc_ok ? good_run + 1 : 0;
  function automatic bit u_dut_flags_ready();
    return good_run >= 3;
  endfunction

endmodule